// File: doc/BRIEF.md
# Quad Double-Buffered Converter Bus Front End

This block sits between an 8-bit processor bus and four 12-bit voltage converters. The processor drives an active-low select, an active-low write strobe, a 4-bit address and a data byte. Each channel's 12-bit code is built in a staging register from two writes: one write carries the low eight bits and a second carries the top four. A separate command then moves staged codes into the output registers that feed the converters. That command can move one channel or all four in the same cycle. Because of this split, a half-written code never reaches an output.

The strobes are asynchronous. They are brought into the system clock domain through a synchronizer. Address and data are held in a shadow register on every clock where both strobes are sampled low. A command runs once, when the synchronized write is seen returning high and select was low in the same sample. A one-cycle pulse for each channel marks every output register that has just been loaded.

Top module: `quad_dac_bus_front`

## Requirements
- R1: A bus cycle has no effect unless select and write are both sampled low. A write strobe with select high changes no staging or output register.
- R2: Address bits [3:2] = 00 load the data byte into bits 7:0 of the staging register of the channel selected by address bits [1:0] (00 = channel 0 up to 11 = channel 3).
- R3: Address bits [3:2] = 01 load data bits 3:0 into bits 11:8 of the selected channel's staging register. Data bits 7:4 are ignored.
- R4: Address bits [3:2] = 10 copy the selected channel's staging register into its output register. The other three outputs do not change, and only that channel's update pulse fires.
- R5: Address bits [3:2] = 11 copy all four staging registers into the output registers in one cycle, whatever address bits [1:0] hold, and all four update pulses fire.
- R6: A staging load never changes an output register and never fires an update pulse.
- R7: A command executes exactly once, on the third rising clock edge counted from the first edge that samples write high after it was low. Select must have been sampled low on the last low-write edge. The address and data used are those sampled on the last edge where both strobes were low.
- R8: Synchronous active-high reset clears every staging and output register to 0x000 and clears the pulses.
- R9: Output words are two's-complement codes passed through unchanged, with 0x7FF the most positive value, 0x000 zero, 0xFFF minus one step and 0x800 the most negative value. Channel n occupies bits 12n+11:12n of the output bus.
- R10: Each update pulse bit is high for exactly one clock, in the cycle where its output register shows the new value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Bus select, active low, asynchronous |
| wr_n | input | 1 | Write strobe, active low, asynchronous |
| addr | input | 4 | Command in [3:2], channel in [1:0] |
| data | input | 8 | Bus data byte |
| code_out | output | 48 | Four 12-bit output codes, channel 0 in the low bits |
| upd_pulse | output | 4 | One-cycle pulse per channel when its output loads |

## Verification
The bench goes after a strobe with select high. A design that decodes only the write strobe would corrupt a staging register in that case, and the error shows up at the next broadcast. It checks that a high-nibble write with junk in the upper data bits leaves those bits out of the code; a design that got this wrong would show a wrong top nibble. It also checks a broadcast issued with a nonzero channel field, which a design that decoded only that field would turn into a single-channel update. Finally, it compares every cycle against a model that knows the exact command latency. An off-by-one synchronizer, a command that repeats while the strobe stays high, or a staging load that leaks to the outputs would each disagree with that model on a specific clock.

// File: rtl/quad_dac_bus_front.sv
module quad_dac_bus_front #(
  parameter int NCH = 4,
  parameter int CW  = 12,
  parameter int BW  = 8,
  parameter int AW  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              wr_n,
  input  logic [AW-1:0]     addr,
  input  logic [BW-1:0]     data,
  output logic [NCH*CW-1:0] code_out,
  output logic [NCH-1:0]    upd_pulse
);
  localparam int SELW = $clog2(NCH);
  localparam int HIW  = CW - BW;

  logic [2:0] wr_sy, cs_sy;
  logic [AW-1:0] a_cap;
  logic [BW-1:0] d_cap;
  logic [CW-1:0] stage_q [NCH];
  logic [CW-1:0] out_q   [NCH];
  logic [NCH-1:0] upd_q;

  wire exec = wr_sy[1] & ~wr_sy[2] & ~cs_sy[2];
  wire [1:0] cmd = a_cap[AW-1:AW-2];
  wire [SELW-1:0] sel = a_cap[SELW-1:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_sy <= '1;
      cs_sy <= '1;
      a_cap <= '0;
      d_cap <= '0;
    end else begin
      wr_sy <= {wr_sy[1:0], wr_n};
      cs_sy <= {cs_sy[1:0], cs_n};
      if (!cs_n && !wr_n) begin
        a_cap <= addr;
        d_cap <= data;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      upd_q <= '0;
      for (int i = 0; i < NCH; i++) begin
        stage_q[i] <= '0;
        out_q[i]   <= '0;
      end
    end else begin
      upd_q <= '0;
      if (exec) begin
        case (cmd)
          2'b00: stage_q[sel][BW-1:0] <= d_cap;
          2'b01: stage_q[sel][CW-1:BW] <= d_cap[HIW-1:0];
          2'b10: begin
            out_q[sel]  <= stage_q[sel];
            upd_q[sel]  <= 1'b1;
          end
          default: begin
            for (int i = 0; i < NCH; i++) out_q[i] <= stage_q[i];
            upd_q <= '1;
          end
        endcase
      end
    end
  end

  for (genvar g = 0; g < NCH; g++) begin : g_out
    assign code_out[g*CW +: CW] = out_q[g];
  end
  assign upd_pulse = upd_q;

  p_quiet_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !exec |=> ($stable(code_out) && upd_pulse == '0));
  p_load_no_out_r6: assert property (@(posedge clk) disable iff (rst)
    (exec && !cmd[1]) |=> ($stable(code_out) && upd_pulse == '0));
  p_single_pulse_r4: assert property (@(posedge clk) disable iff (rst)
    (exec && cmd == 2'b10) |=> $countones(upd_pulse) == 1);
  p_all_pulse_r5: assert property (@(posedge clk) disable iff (rst)
    (exec && cmd == 2'b11) |=> upd_pulse == '1);
  p_pulse_width_r10: assert property (@(posedge clk) disable iff (rst)
    (upd_pulse != '0) |=> upd_pulse == '0);
endmodule

// File: tb/quad_dac_bus_front_bench.sv
module quad_dac_bus_front_bench;
  logic clk = 0, rst = 1, cs_n = 1, wr_n = 1;
  logic [3:0] addr = '0;
  logic [7:0] data = '0;
  logic [47:0] code_out;
  logic [3:0] upd_pulse;
  int checks = 0, errors = 0;

  quad_dac_bus_front u_quad_dac_bus_front (
    .clk(clk), .rst(rst), .cs_n(cs_n), .wr_n(wr_n), .addr(addr),
    .data(data), .code_out(code_out), .upd_pulse(upd_pulse));

  always #4 clk = ~clk;

  int m_stage[4], m_out[4], m_upd;
  int wh[3], ch[3];
  int cap_a, cap_d;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < 4; i++) begin m_stage[i] = 0; m_out[i] = 0; end
      m_upd = 0; cap_a = 0; cap_d = 0;
      for (int i = 0; i < 3; i++) begin wh[i] = 1; ch[i] = 1; end
    end else begin
      m_upd = 0;
      if (wh[1] == 1 && wh[2] == 0 && ch[2] == 0) begin
        case (cap_a / 4)
          0: m_stage[cap_a % 4] = (m_stage[cap_a % 4] & 'hF00) | cap_d;
          1: m_stage[cap_a % 4] = (m_stage[cap_a % 4] & 'h0FF) | ((cap_d % 16) * 256);
          2: begin m_out[cap_a % 4] = m_stage[cap_a % 4]; m_upd = 1 << (cap_a % 4); end
          default: begin
            for (int i = 0; i < 4; i++) m_out[i] = m_stage[i];
            m_upd = 15;
          end
        endcase
      end
      wh[2] = wh[1]; wh[1] = wh[0]; wh[0] = wr_n;
      ch[2] = ch[1]; ch[1] = ch[0]; ch[0] = cs_n;
      if (!cs_n && !wr_n) begin cap_a = addr; cap_d = data; end
    end
  end

  task automatic check(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  always @(negedge clk) if (!rst) begin
    for (int i = 0; i < 4; i++)
      check("R7 model out", int'(code_out[i*12 +: 12]), m_out[i]);
    check("R10 model pulse", int'(upd_pulse), m_upd);
  end

  task automatic bus(input logic sel_n, input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cs_n = sel_n; wr_n = 0; addr = a; data = d;
    repeat (3) @(negedge clk);
    wr_n = 1;
    @(negedge clk); cs_n = 1; addr = 4'h0; data = 8'h00;
    repeat (4) @(negedge clk);
  endtask

  function automatic int outc(int i);
    return int'(code_out[i*12 +: 12]);
  endfunction

  initial begin
    #(200000 * 8);
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) check("R8 reset out", outc(i), 0);
    check("R8 reset pulse", int'(upd_pulse), 0);

    bus(0, 4'b0000, 8'hFF);
    bus(0, 4'b0100, 8'h07);
    check("R6 load keeps out0", outc(0), 0);
    bus(0, 4'b1000, 8'h00);
    check("R4 ch0 updated", outc(0), 'h7FF);
    check("R9 max positive", outc(0), 'h7FF);
    check("R4 ch1 unchanged", outc(1), 0);

    bus(0, 4'b0001, 8'h34);
    bus(0, 4'b0101, 8'hF8);
    bus(1, 4'b0001, 8'h99);
    bus(1, 4'b1101, 8'h00);
    check("R1 select high no update", outc(1), 0);
    bus(0, 4'b0010, 8'hFF);
    bus(0, 4'b0110, 8'h0F);
    bus(0, 4'b0011, 8'h00);
    bus(0, 4'b0111, 8'h58);
    bus(0, 4'b1110, 8'h00);
    check("R3 nibble only", outc(1), 'h834);
    check("R1 ignored low byte", outc(1) & 'hFF, 'h34);
    check("R5 ch0", outc(0), 'h7FF);
    check("R9 minus one", outc(2), 'hFFF);
    check("R9 most negative", outc(3), 'h800);

    bus(0, 4'b0010, 8'h01);
    bus(0, 4'b0110, 8'h00);
    check("R2 load keeps out2", outc(2), 'hFFF);
    bus(0, 4'b1010, 8'h00);
    check("R2 low byte landed", outc(2), 'h001);
    check("R4 ch3 unchanged", outc(3), 'h800);

    @(negedge clk); rst = 1;
    @(negedge clk); rst = 0;
    @(negedge clk);
    for (int i = 0; i < 4; i++) check("R8 mid reset", outc(i), 0);
    bus(0, 4'b1111, 8'h00);
    for (int i = 0; i < 4; i++) check("R8 stage cleared", outc(i), 0);

    repeat (4) @(negedge clk);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule